// File: doc/BRIEF.md
# Hop-Class Packet Slot Allocator

This block manages the slot map of a node's transmit staging buffer. The buffer holds packets that the node sends itself and packets that are parked while in transit. Each slot holds one fixed-length packet. The block tracks only which slots are occupied. The packet words and the hop-distance calculation belong to neighbouring logic.

Slots are split into two pools. The open pool accepts any packet. The reserved pool is divided into `NUM_CLASSES` classes, numbered 1 to K, and class c may hold only packets with c or fewer hops left to travel. The reserved pool is used only while the open pool is full. Reserving space by remaining distance in this way keeps buffered in-transit traffic free of deadlock.

A requester raises `alloc_req` with the packet's remaining hop count. One cycle later it sees either a grant with a slot index or a refusal. A refused request leaves no trace, so the requester simply retries. Slots are returned with `free_req` and a slot index. Allocation and release can both happen in the same cycle.

Top module: `hopbuf_alloc`

## Requirements
- R1: After synchronous reset, every slot is empty, all occupancy counts read zero, and `grant_o`, `refuse_o` and `free_err_o` are low.
- R2: While any open-pool slot (indices 0 to GEN_SLOTS-1) is free, a request is granted the lowest free open-pool index, whatever its hop count.
- R3: When the open pool is full, a request with hop count h is granted from the lowest-numbered class c with c ≥ max(h,1) that has a free slot. Class c occupies indices GEN_SLOTS+(c-1)*CLASS_SLOTS upward, and the lowest free index inside that class is chosen.
- R4: If no permitted class has room, the request is refused, and no slot or count changes because of it.
- R5: Every request produces exactly one of `grant_o` or `refuse_o` in the following cycle. Neither output rises without a request.
- R6: A slot released in some cycle cannot be granted to a request made in that same cycle. It can be granted from the next cycle onward.
- R7: Releasing a slot that is not held, or an index ≥ the total slot count, pulses `free_err_o` in the next cycle and changes nothing.
- R8: `gen_used_o` and each `CW`-bit field c-1 of `cls_used_o` give the held slots of the open pool and of class c. Both are updated in the cycle after any grant or release.
- R9: A request and a valid release in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Slot request strobe |
| alloc_hops | input | HOP_W | Hops the packet still has to travel |
| free_req | input | 1 | Slot release strobe |
| free_slot | input | SW | Index of the slot being released |
| grant_o | output | 1 | Request granted (one cycle after request) |
| refuse_o | output | 1 | Request refused (one cycle after request) |
| grant_slot_o | output | SW | Granted slot index, valid with `grant_o` |
| free_err_o | output | 1 | Release of an unheld or out-of-range slot |
| gen_used_o | output | GW | Held slots in the open pool |
| cls_used_o | output | NUM_CLASSES*CW | Held slots per class, class 1 in the low field |

## Verification
The hardest situation to reach is a completely full open pool with a mixed pattern of full and partly free classes. This is the only state in which the hop-class restriction is visible, including a refusal while a lower class still has room. The directed stimulus first fills the open pool with varied hop counts, then walks the classes with chosen hop counts until a low class has space but a large hop count is still refused. A release and a request in the same cycle are then aimed at a full buffer. A long random phase follows, with releases biased toward held slots, and a behavioural model checks every cycle.

// File: rtl/hopbuf_pkg.sv
`timescale 1ns/1ps
package hopbuf_pkg;
  typedef enum logic [1:0] {
    RESP_NONE   = 2'd0,
    RESP_GRANT  = 2'd1,
    RESP_REFUSE = 2'd2
  } resp_e;
endpackage

// File: rtl/hopbuf_find_free.sv
`timescale 1ns/1ps
module hopbuf_find_free #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  busy_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/hopbuf_class_pick.sv
`timescale 1ns/1ps
module hopbuf_class_pick #(
  parameter int NUM_CLASSES = 4,
  parameter int HOP_W       = 3,
  localparam int KI = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic [NUM_CLASSES-1:0] avail_i,
  input  logic [HOP_W-1:0]       hops_i,
  output logic                   hit_o,
  output logic [KI-1:0]          cls_o
);
  // entry c describes class c+1; lowest eligible class wins
  always_comb begin
    hit_o = 1'b0;
    cls_o = '0;
    for (int c = NUM_CLASSES - 1; c >= 0; c--) begin
      if (avail_i[c] && ((c + 1) >= int'(hops_i))) begin
        hit_o = 1'b1;
        cls_o = KI'(c);
      end
    end
  end
endmodule

// File: rtl/hopbuf_alloc.sv
`timescale 1ns/1ps
module hopbuf_alloc
  import hopbuf_pkg::*;
#(
  parameter int GEN_SLOTS   = 8,
  parameter int NUM_CLASSES = 4,
  parameter int CLASS_SLOTS = 2,
  parameter int HOP_W       = 3,
  localparam int N  = GEN_SLOTS + NUM_CLASSES * CLASS_SLOTS,
  localparam int SW = $clog2(N + 1),
  localparam int GW = $clog2(GEN_SLOTS + 1),
  localparam int CW = $clog2(CLASS_SLOTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_req,
  input  logic [HOP_W-1:0]          alloc_hops,
  input  logic                      free_req,
  input  logic [SW-1:0]             free_slot,
  output logic                      grant_o,
  output logic                      refuse_o,
  output logic [SW-1:0]             grant_slot_o,
  output logic                      free_err_o,
  output logic [GW-1:0]             gen_used_o,
  output logic [NUM_CLASSES*CW-1:0] cls_used_o
);
  localparam int GI = (GEN_SLOTS > 1) ? $clog2(GEN_SLOTS) : 1;
  localparam int CI = (CLASS_SLOTS > 1) ? $clog2(CLASS_SLOTS) : 1;
  localparam int KI = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1;

  logic [N-1:0]  busy_q, busy_d;
  resp_e         resp_q;
  logic [SW-1:0] slot_q;
  logic          err_q;
  logic [GW-1:0] gen_cnt_q;
  logic [NUM_CLASSES*CW-1:0] cls_cnt_q, cls_cnt_d;

  // open pool search
  logic          gen_found;
  logic [GI-1:0] gen_idx;
  hopbuf_find_free #(.W(GEN_SLOTS)) u_gen_free (
    .busy_i (busy_q[GEN_SLOTS-1:0]),
    .found_o(gen_found),
    .idx_o  (gen_idx)
  );

  // per-class search
  logic [NUM_CLASSES-1:0] cls_found;
  logic [CI-1:0]          cls_idx [NUM_CLASSES];
  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    hopbuf_find_free #(.W(CLASS_SLOTS)) u_cls_free (
      .busy_i (busy_q[GEN_SLOTS + c*CLASS_SLOTS +: CLASS_SLOTS]),
      .found_o(cls_found[c]),
      .idx_o  (cls_idx[c])
    );
    assign cls_cnt_d[c*CW +: CW] =
      CW'($countones(busy_d[GEN_SLOTS + c*CLASS_SLOTS +: CLASS_SLOTS]));
  end

  logic          cls_hit;
  logic [KI-1:0] cls_sel;
  hopbuf_class_pick #(.NUM_CLASSES(NUM_CLASSES), .HOP_W(HOP_W)) u_pick (
    .avail_i(cls_found),
    .hops_i (alloc_hops),
    .hit_o  (cls_hit),
    .cls_o  (cls_sel)
  );

  logic          pick_ok;
  logic [SW-1:0] pick_slot;
  always_comb begin
    pick_ok   = 1'b0;
    pick_slot = '0;
    if (gen_found) begin
      pick_ok   = 1'b1;
      pick_slot = SW'(gen_idx);
    end else if (cls_hit) begin
      pick_ok   = 1'b1;
      pick_slot = SW'(GEN_SLOTS) + SW'(cls_sel) * SW'(CLASS_SLOTS)
                + SW'(cls_idx[cls_sel]);
    end
  end

  // release decode: an out-of-range index shifts to an empty mask
  logic [N-1:0] free_mask, take_mask;
  logic         free_ok, alloc_fire;
  always_comb begin
    free_mask  = N'(1) << free_slot;
    take_mask  = N'(1) << pick_slot;
    free_ok    = free_req && |(free_mask & busy_q);
    alloc_fire = alloc_req && pick_ok;
    busy_d     = (busy_q | (alloc_fire ? take_mask : '0))
               & ~(free_ok ? free_mask : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= '0;
      resp_q    <= RESP_NONE;
      slot_q    <= '0;
      err_q     <= 1'b0;
      gen_cnt_q <= '0;
      cls_cnt_q <= '0;
    end else begin
      busy_q    <= busy_d;
      resp_q    <= !alloc_req ? RESP_NONE : (pick_ok ? RESP_GRANT : RESP_REFUSE);
      slot_q    <= alloc_fire ? pick_slot : slot_q;
      err_q     <= free_req && !free_ok;
      gen_cnt_q <= GW'($countones(busy_d[GEN_SLOTS-1:0]));
      cls_cnt_q <= cls_cnt_d;
    end
  end

  assign grant_o      = (resp_q == RESP_GRANT);
  assign refuse_o     = (resp_q == RESP_REFUSE);
  assign grant_slot_o = slot_q;
  assign free_err_o   = err_q;
  assign gen_used_o   = gen_cnt_q;
  assign cls_used_o   = cls_cnt_q;
endmodule

// File: rtl/hopbuf_alloc_chk.sv
`timescale 1ns/1ps
module hopbuf_alloc_chk #(
  parameter int GEN_SLOTS   = 8,
  parameter int NUM_CLASSES = 4,
  parameter int CLASS_SLOTS = 2,
  parameter int HOP_W       = 3,
  localparam int N  = GEN_SLOTS + NUM_CLASSES * CLASS_SLOTS,
  localparam int SW = $clog2(N + 1),
  localparam int GW = $clog2(GEN_SLOTS + 1),
  localparam int CW = $clog2(CLASS_SLOTS + 1)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      alloc_req,
  input logic                      free_req,
  input logic                      grant_o,
  input logic                      refuse_o,
  input logic [SW-1:0]             grant_slot_o,
  input logic                      free_err_o,
  input logic [GW-1:0]             gen_used_o,
  input logic [NUM_CLASSES*CW-1:0] cls_used_o
);
  assert_one_resp_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant_o, refuse_o}));

  assert_resp_follows_req_R5: assert property (@(posedge clk) disable iff (rst)
    alloc_req |=> (grant_o || refuse_o));

  assert_no_spont_resp_R5: assert property (@(posedge clk) disable iff (rst)
    (grant_o || refuse_o) |-> $past(alloc_req));

  assert_open_pool_first_R2: assert property (@(posedge clk) disable iff (rst)
    (grant_o && (grant_slot_o >= SW'(GEN_SLOTS))) |-> ($past(gen_used_o) == GW'(GEN_SLOTS)));

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> (grant_slot_o < SW'(N)));

  assert_refuse_only_full_R4: assert property (@(posedge clk) disable iff (rst)
    refuse_o |-> ($past(gen_used_o) == GW'(GEN_SLOTS)));

  assert_refuse_no_change_R4: assert property (@(posedge clk) disable iff (rst)
    (refuse_o && !$past(free_req)) |-> ($stable(gen_used_o) && $stable(cls_used_o)));

  assert_err_needs_free_R7: assert property (@(posedge clk) disable iff (rst)
    free_err_o |-> $past(free_req));

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cap
    assert_class_cap_R8: assert property (@(posedge clk) disable iff (rst)
      cls_used_o[c*CW +: CW] <= CW'(CLASS_SLOTS));
  end
endmodule

bind hopbuf_alloc hopbuf_alloc_chk #(
  .GEN_SLOTS(GEN_SLOTS), .NUM_CLASSES(NUM_CLASSES),
  .CLASS_SLOTS(CLASS_SLOTS), .HOP_W(HOP_W)
) u_chk (
  .clk(clk), .rst(rst), .alloc_req(alloc_req), .free_req(free_req),
  .grant_o(grant_o), .refuse_o(refuse_o), .grant_slot_o(grant_slot_o),
  .free_err_o(free_err_o), .gen_used_o(gen_used_o), .cls_used_o(cls_used_o)
);

// File: tb/tb_hopbuf_alloc.sv
`timescale 1ns/1ps
module tb_hopbuf_alloc;
  localparam int G  = 8;
  localparam int K  = 4;
  localparam int CS = 2;
  localparam int HW = 3;
  localparam int N  = G + K * CS;
  localparam int SW = $clog2(N + 1);
  localparam int GW = $clog2(G + 1);
  localparam int CW = $clog2(CS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_req = 1'b0;
  logic [HW-1:0] alloc_hops = '0;
  logic free_req = 1'b0;
  logic [SW-1:0] free_slot = '0;
  logic grant_o, refuse_o, free_err_o;
  logic [SW-1:0] grant_slot_o;
  logic [GW-1:0] gen_used_o;
  logic [K*CW-1:0] cls_used_o;

  always #2.5 clk = ~clk;

  hopbuf_alloc #(.GEN_SLOTS(G), .NUM_CLASSES(K), .CLASS_SLOTS(CS), .HOP_W(HW)) dut (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_hops(alloc_hops),
    .free_req(free_req), .free_slot(free_slot), .grant_o(grant_o),
    .refuse_o(refuse_o), .grant_slot_o(grant_slot_o), .free_err_o(free_err_o),
    .gen_used_o(gen_used_o), .cls_used_o(cls_used_o)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  mb [N];
  bit  done = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_counts(string tag);
    int g = 0;
    for (int i = 0; i < G; i++) g += int'(mb[i]);
    check(int'(gen_used_o) == g, {"R8 open count ", tag}, int'(gen_used_o), g);
    for (int c = 0; c < K; c++) begin
      int e = 0;
      for (int j = 0; j < CS; j++) e += int'(mb[G + c*CS + j]);
      check(int'(cls_used_o[c*CW +: CW]) == e, {"R8 class count ", tag},
            int'(cls_used_o[c*CW +: CW]), e);
    end
  endtask

  // one clock: drive, predict from the model, compare after the edge
  task automatic step(bit areq, int hops, bit freq, int fslot, string tag);
    int  e_slot = -1;
    bit  e_err;
    bit  hit = 1'b0;
    int  lim;
    @(negedge clk);
    alloc_req  = areq;
    alloc_hops = HW'(hops);
    free_req   = freq;
    free_slot  = SW'(fslot);
    if (areq) begin
      for (int i = 0; i < G; i++)
        if (!hit && !mb[i]) begin hit = 1'b1; e_slot = i; end
      lim = (hops < 1) ? 1 : hops;
      for (int c = 1; c <= K; c++)
        for (int j = 0; j < CS; j++)
          if (!hit && c >= lim && !mb[G + (c-1)*CS + j]) begin
            hit = 1'b1; e_slot = G + (c-1)*CS + j;
          end
    end
    e_err = freq && !(fslot < N && mb[fslot]);
    if (freq && !e_err) mb[fslot] = 1'b0;
    if (hit) mb[e_slot] = 1'b1;
    @(posedge clk);
    #1;
    check(grant_o == (areq && hit), {"R2 R3 R5 grant ", tag}, int'(grant_o), int'(areq && hit));
    check(refuse_o == (areq && !hit), {"R4 R5 refuse ", tag}, int'(refuse_o), int'(areq && !hit));
    if (areq && hit)
      check(int'(grant_slot_o) == e_slot, {"R2 R3 slot ", tag}, int'(grant_slot_o), e_slot);
    check(free_err_o == e_err, {"R7 free error ", tag}, int'(free_err_o), int'(e_err));
    check_counts(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(!grant_o && !refuse_o && !free_err_o, "R1 outputs idle", int'(grant_o | refuse_o | free_err_o), 0);
    check_counts("R1 reset");

    // R2: open pool first, any hop count
    for (int i = 0; i < G; i++) step(1'b1, i % 7, 1'b0, 0, "R2 fill open");
    // R3: classes by remaining hops
    step(1'b1, 2, 1'b0, 0, "R3 hop2 class2");
    step(1'b1, 2, 1'b0, 0, "R3 hop2 class2 second");
    step(1'b1, 2, 1'b0, 0, "R3 hop2 spill class3");
    step(1'b1, 1, 1'b0, 0, "R3 hop1 class1");
    step(1'b1, 1, 1'b0, 0, "R3 hop1 class1 second");
    step(1'b1, 1, 1'b0, 0, "R3 hop1 spill class3");
    step(1'b1, 1, 1'b0, 0, "R3 hop1 spill class4");
    step(1'b1, 5, 1'b0, 0, "R4 hops beyond classes");
    step(1'b1, 4, 1'b0, 0, "R3 hop4 class4");
    step(1'b1, 0, 1'b0, 0, "R4 all full");
    // R6 R9: release and request together on a full buffer
    step(1'b1, 1, 1'b1, 3, "R6 R9 same cycle");
    step(1'b1, 6, 1'b0, 0, "R6 freed slot next cycle");
    // R7: double and out-of-range release
    step(1'b0, 0, 1'b1, 9, "R7 valid release");
    step(1'b0, 0, 1'b1, 9, "R7 double release");
    step(1'b0, 0, 1'b1, 20, "R7 out of range");
    // R3: low class free but too far to use it
    step(1'b1, 3, 1'b0, 0, "R3 R4 class1 barred");
    step(1'b1, 1, 1'b0, 0, "R3 class1 reuse");
    step(1'b0, 0, 1'b0, 0, "idle");
    // drain
    for (int i = 0; i < N; i++) step(1'b0, 0, 1'b1, i, "R8 drain");
    // random phase, R9 mixes
    for (int t = 0; t < 2000; t++) begin
      bit a  = ($urandom % 3) != 0;
      bit f  = ($urandom % 2) != 0;
      int h  = int'($urandom % 7);
      int fs = int'($urandom % 20);
      if (($urandom % 4) != 0) begin
        for (int k = 0; k < N; k++) if (mb[(fs + k) % N]) begin fs = (fs + k) % N; break; end
      end
      step(a, h, f, fs, "R9 random");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule